// File: doc/BRIEF.md
# Two-Wire Byte Memory Slave

This block is the protocol engine that sits between a two-wire serial bus and a byte-wide memory of up to 64 KiB; by default the memory holds 32,768 bytes. The system clock oversamples the bus clock and data lines. The block detects bus start and stop events and matches its device address. It receives and transmits bytes most significant bit first, and it drives the acknowledge slot. The memory side is a plain port. The address comes from the block's internal word-address counter. A write strobe carries the data for one cycle. The read data is expected one system clock after the address changes.

A master writes by sending the device address with the direction bit clear, then two word-address bytes, then any number of data bytes. The data bytes wrap inside one page. To read, the master sends the device address with the direction bit set, and data comes out from the counter position. A random read first loads the counter with a write that carries only the two address bytes. Every acknowledged byte of a read advances the counter across the whole array.

Top module: `twi_mem_slave`

## Requirements
- R1: After reset the block drives nothing on the data line and issues no write. A start (data falling while clock is high) begins address matching from any state. A stop (data rising while clock is high) returns the block to idle.
- R2: The first byte after a start is the device address, sent most significant bit first: bits 7..4 = 1010, bits 3..1 = the strap inputs, bit 0 = direction (1 = read). On a mismatch the block does not acknowledge, and it ignores all later bytes until the next start.
- R3: The block acknowledges by pulling the data line low for the ninth clock of each byte it accepts. Its data-line output changes only while the bus clock is low.
- R4: In a write, the two bytes after the device address are the high and low word address and are acknowledged. Each following data byte is acknowledged and written to the counter address with a one-cycle write strobe.
- R5: During writes the counter increments only inside a page of PAGE_BYTES bytes. The byte after the last one of a page lands on the first byte of the same page.
- R6: A read that is not preceded by address bytes returns the byte at the counter. The counter then holds the last accessed address plus one, and it persists across transactions.
- R7: A write that carries only the two address bytes, followed by a repeated start and a read device address, returns data from the newly loaded address.
- R8: During a read, each master acknowledge (data low on the ninth clock) advances the counter and sends the next byte. A master non-acknowledge makes the block release the data line.
- R9: During reads the counter wraps from the last array address to address 0.
- R10: Word-address bits above ADDR_W are ignored, so address 0x8005 selects byte 0x0005.
- R11: A start that arrives in the middle of a byte abandons that byte without any memory write and restarts address matching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe_o | output | 1 | When high, the data line is pulled low (open drain) |
| strap_i | input | 3 | Board straps that select the device address bits |
| mem_addr_o | output | ADDR_W | Memory address (the word-address counter) |
| mem_we_o | output | 1 | One-cycle write strobe |
| mem_wdata_o | output | 8 | Write data |
| mem_rdata_i | input | 8 | Read data, valid one clock after the address changes |

## Verification
Two events can fall on the same system clock edge. On a sequential read across the top of the array, the counter wrap and the release of the data line for the master's acknowledge slot happen together. The bench reads three bytes from 0x7FFE and expects the third byte to be the content of address 0. A master start can also arrive in the middle of a data byte that would otherwise end in a write. The bench sends four bits of data and then a repeated start. It judges the result by checking that no write strobe appears and that the following read comes from the loaded address.

// File: rtl/twi_pkg.sv
package twi_pkg;

    localparam logic [3:0] DEV_PREFIX = 4'b1010;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_RX_ACK,
        ST_TX,
        ST_TX_ACK
    } twi_state_e;

    typedef enum logic [1:0] {
        K_DEV,
        K_AHI,
        K_ALO,
        K_DATA
    } rx_kind_e;

    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } line_ev_t;

    function automatic rx_kind_e next_kind(input rx_kind_e k);
        case (k)
            K_DEV:   return K_AHI;
            K_AHI:   return K_ALO;
            default: return K_DATA;
        endcase
    endfunction

    function automatic logic dev_match(input logic [7:0] b, input logic [2:0] strap);
        return (b[7:4] == DEV_PREFIX) && (b[3:1] == strap);
    endfunction

endpackage

// File: rtl/twi_line_mon.sv
module twi_line_mon
    import twi_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_i,
    input  logic     sda_i,
    output line_ev_t ev_o
);
    logic [SYNC_STAGES-1:0] scl_chain;
    logic [SYNC_STAGES-1:0] sda_chain;
    logic scl_s, sda_s, scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_chain <= '1;
            sda_chain <= '1;
            scl_q     <= 1'b1;
            sda_q     <= 1'b1;
        end else begin
            scl_chain <= {scl_chain[SYNC_STAGES-2:0], scl_i};
            sda_chain <= {sda_chain[SYNC_STAGES-2:0], sda_i};
            scl_q     <= scl_s;
            sda_q     <= sda_s;
        end
    end

    assign scl_s = scl_chain[SYNC_STAGES-1];
    assign sda_s = sda_chain[SYNC_STAGES-1];

    always_comb begin
        ev_o.scl      = scl_s;
        ev_o.sda      = sda_s;
        ev_o.scl_rise = scl_s & ~scl_q;
        ev_o.scl_fall = ~scl_s & scl_q;
        ev_o.start    = scl_s & scl_q & sda_q & ~sda_s;
        ev_o.stop     = scl_s & scl_q & ~sda_q & sda_s;
    end

    AST_EVENTS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(ev_o.start && ev_o.stop) && !(ev_o.scl_rise && ev_o.scl_fall)); // R1
endmodule

// File: rtl/twi_addr_ctr.sv
module twi_addr_ctr #(
    parameter int ADDR_W     = 15,
    parameter int PAGE_BYTES = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_en,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              inc_page,
    input  logic              inc_full,
    output logic [ADDR_W-1:0] addr_o
);
    localparam int PG_W = $clog2(PAGE_BYTES);

    logic [ADDR_W-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
        end else if (load_en) begin
            addr_q <= load_val;
        end else if (inc_full) begin
            addr_q <= addr_q + 1'b1;
        end else if (inc_page) begin
            addr_q <= {addr_q[ADDR_W-1:PG_W], addr_q[PG_W-1:0] + 1'b1};
        end
    end

    assign addr_o = addr_q;

    AST_READ_WRAP: assert property (@(posedge clk) disable iff (rst)
        ($past(inc_full) && !$past(load_en) && ($past(addr_q) == {ADDR_W{1'b1}}))
        |-> (addr_q == '0)); // R9
endmodule

// File: rtl/twi_mem_slave.sv
module twi_mem_slave
    import twi_pkg::*;
#(
    parameter int ADDR_W      = 15,
    parameter int PAGE_BYTES  = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    input  logic [2:0]        strap_i,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              mem_we_o,
    output logic [7:0]        mem_wdata_o,
    input  logic [7:0]        mem_rdata_i
);
    localparam int PG_W = $clog2(PAGE_BYTES);
    localparam int HI_W = ADDR_W - 8;

    line_ev_t    ev;
    twi_state_e  st;
    rx_kind_e    kind;
    logic [3:0]  cnt;
    logic [7:0]  sh;
    logic        rw;
    logic [HI_W-1:0] hi_q;
    logic        oe;
    logic        we_q;
    logic [7:0]  wd_q;
    logic        mack;
    logic        quiet;
    logic        ctr_load, ctr_inc_full;
    logic [ADDR_W-1:0] ctr;

    twi_line_mon #(.SYNC_STAGES(SYNC_STAGES)) u_line (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev_o  (ev)
    );

    assign quiet        = ~ev.start & ~ev.stop;
    assign ctr_load     = quiet && (st == ST_RX) && ev.scl_fall && (cnt == 4'd8) && (kind == K_ALO);
    assign ctr_inc_full = quiet && (st == ST_TX) && ev.scl_fall && (cnt == 4'd7);

    twi_addr_ctr #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_ctr (
        .clk      (clk),
        .rst      (rst),
        .load_en  (ctr_load),
        .load_val ({hi_q, sh}),
        .inc_page (we_q),
        .inc_full (ctr_inc_full),
        .addr_o   (ctr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ST_IDLE;
            kind <= K_DEV;
            cnt  <= '0;
            sh   <= '0;
            rw   <= 1'b0;
            hi_q <= '0;
            oe   <= 1'b0;
            we_q <= 1'b0;
            wd_q <= '0;
            mack <= 1'b0;
        end else begin
            we_q <= 1'b0;
            if (ev.start) begin
                st   <= ST_RX;
                kind <= K_DEV;
                cnt  <= '0;
                oe   <= 1'b0;
            end else if (ev.stop) begin
                st <= ST_IDLE;
                oe <= 1'b0;
            end else begin
                case (st)
                    ST_RX: begin
                        if (ev.scl_rise && cnt < 4'd8) begin
                            sh  <= {sh[6:0], ev.sda};
                            cnt <= cnt + 1'b1;
                        end else if (ev.scl_fall && cnt == 4'd8) begin
                            case (kind)
                                K_DEV: begin
                                    if (dev_match(sh, strap_i)) begin
                                        rw <= sh[0];
                                        oe <= 1'b1;
                                        st <= ST_RX_ACK;
                                    end else begin
                                        st <= ST_IDLE;
                                    end
                                end
                                K_AHI: begin
                                    hi_q <= sh[HI_W-1:0];
                                    oe   <= 1'b1;
                                    st   <= ST_RX_ACK;
                                end
                                K_ALO: begin
                                    oe <= 1'b1;
                                    st <= ST_RX_ACK;
                                end
                                default: begin
                                    we_q <= 1'b1;
                                    wd_q <= sh;
                                    oe   <= 1'b1;
                                    st   <= ST_RX_ACK;
                                end
                            endcase
                        end
                    end
                    ST_RX_ACK: begin
                        if (ev.scl_fall) begin
                            cnt <= '0;
                            if (kind == K_DEV && rw) begin
                                st <= ST_TX;
                                sh <= mem_rdata_i;
                                oe <= ~mem_rdata_i[7];
                            end else begin
                                st   <= ST_RX;
                                kind <= next_kind(kind);
                                oe   <= 1'b0;
                            end
                        end
                    end
                    ST_TX: begin
                        if (ev.scl_fall) begin
                            if (cnt == 4'd7) begin
                                st <= ST_TX_ACK;
                                oe <= 1'b0;
                            end else begin
                                sh  <= {sh[6:0], 1'b0};
                                oe  <= ~sh[6];
                                cnt <= cnt + 1'b1;
                            end
                        end
                    end
                    ST_TX_ACK: begin
                        if (ev.scl_rise) begin
                            mack <= ~ev.sda;
                        end else if (ev.scl_fall) begin
                            if (mack) begin
                                st  <= ST_TX;
                                cnt <= '0;
                                sh  <= mem_rdata_i;
                                oe  <= ~mem_rdata_i[7];
                            end else begin
                                st <= ST_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign sda_oe_o    = oe;
    assign mem_addr_o  = ctr;
    assign mem_we_o    = we_q;
    assign mem_wdata_o = wd_q;

    AST_SDA_CHANGES_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
        (sda_oe_o != $past(sda_oe_o)) |-> !$past(ev.scl)); // R3
    AST_WE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        mem_we_o |=> !mem_we_o); // R4
    AST_WRITE_IN_PAGE: assert property (@(posedge clk) disable iff (rst)
        $past(mem_we_o) |-> (mem_addr_o[ADDR_W-1:PG_W] == $past(mem_addr_o[ADDR_W-1:PG_W]))); // R5
    AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE) |-> !sda_oe_o); // R2
    AST_START_RESTARTS: assert property (@(posedge clk) disable iff (rst)
        $past(ev.start) |-> (st == ST_RX && kind == K_DEV && cnt == 4'd0 && !sda_oe_o && !mem_we_o)); // R11
endmodule

// File: tb/test_twi_mem_slave.sv
module test_twi_mem_slave;
    localparam int Q = 8;
    localparam int AW = 15;
    localparam logic [2:0] STRAP = 3'b101;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic [AW-1:0] mem_addr;
    logic mem_we;
    logic [7:0] mem_wdata;
    logic [7:0] mem_rdata = 8'h00;
    wire  sda_line = sda_m & ~sda_oe;

    int checks = 0;
    int failures = 0;
    int oe_viol = 0;
    bit done = 1'b0;
    int ref_ctr = 0;
    logic [7:0] ref_mem [int];
    logic [7:0] dmem [int];
    int exp_wr_q [$];

    always #10 clk = ~clk;

    twi_mem_slave i_twi_mem_slave (
        .clk         (clk),
        .rst         (rst),
        .scl_i       (scl_m),
        .sda_i       (sda_line),
        .sda_oe_o    (sda_oe),
        .strap_i     (STRAP),
        .mem_addr_o  (mem_addr),
        .mem_we_o    (mem_we),
        .mem_wdata_o (mem_wdata),
        .mem_rdata_i (mem_rdata)
    );

    function automatic logic [7:0] dflt(input int a);
        return 8'((a * 7 + 3) & 255);
    endfunction

    function automatic logic [7:0] ref_val(input int a);
        return ref_mem.exists(a) ? ref_mem[a] : dflt(a);
    endfunction

    always @(posedge clk) begin
        if (mem_we) dmem[int'(mem_addr)] = mem_wdata;
        mem_rdata <= dmem.exists(int'(mem_addr)) ? dmem[int'(mem_addr)] : dflt(int'(mem_addr));
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // per-clock comparison against the reference write stream
    logic oe_prev = 1'b0;
    logic scl_prev = 1'b1;
    always begin
        @(posedge clk);
        #2;
        if (!rst) begin
            if (sda_oe !== oe_prev && scl_m && scl_prev) oe_viol++;
            if (mem_we) begin
                if (exp_wr_q.size() == 0) begin
                    chk(1'b0, "R11 unexpected write", int'(mem_addr), -1);
                end else begin
                    int e;
                    e = exp_wr_q.pop_front();
                    chk(int'(mem_addr) == (e >> 8) && int'(mem_wdata) == (e & 255),
                        "R4 write addr/data", (int'(mem_addr) << 8) | int'(mem_wdata), e);
                end
            end
        end
        oe_prev  = sda_oe;
        scl_prev = scl_m;
    end

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bitx(input logic b, output logic s);
        sda_m = b; wq();
        scl_m = 1'b1; wq();
        s = sda_line; wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic send_start();
        sda_m = 1'b1; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b0; wq();
        scl_m = 1'b0; wq();
    endtask

    task automatic send_stop();
        sda_m = 1'b0; wq();
        scl_m = 1'b1; wq();
        sda_m = 1'b1; wq();
    endtask

    task automatic wbyte(input logic [7:0] d, input logic exp_ack, input string tag);
        logic s;
        for (int i = 7; i >= 0; i--) bitx(d[i], s);
        bitx(1'b1, s);
        chk((!s) == exp_ack, tag, int'(!s), int'(exp_ack));
    endtask

    task automatic rbyte(input logic [7:0] exp, input logic ack, input string tag);
        logic s;
        logic [7:0] v;
        for (int i = 7; i >= 0; i--) begin
            bitx(1'b1, s);
            v[i] = s;
        end
        chk(v == exp, tag, int'(v), int'(exp));
        bitx(!ack, s);
    endtask

    function automatic logic [7:0] devb(input logic r);
        return {4'b1010, STRAP, r};
    endfunction

    task automatic send_addr(input int addr, input string tag);
        wbyte(devb(1'b0), 1'b1, tag);
        wbyte(8'((addr >> 8) & 255), 1'b1, tag);
        wbyte(8'(addr & 255), 1'b1, tag);
        ref_ctr = addr & 32'h7FFF;
    endtask

    task automatic wr_seq(input int addr, input logic [7:0] data [$], input string tag);
        send_start();
        send_addr(addr, tag);
        foreach (data[k]) begin
            exp_wr_q.push_back((ref_ctr << 8) | int'(data[k]));
            ref_mem[ref_ctr] = data[k];
            ref_ctr = (ref_ctr & 32'h7FC0) | ((ref_ctr + 1) & 32'h3F);
            wbyte(data[k], 1'b1, tag);
        end
        send_stop();
    endtask

    task automatic rd_cur(input int n, input string tag);
        send_start();
        wbyte(devb(1'b1), 1'b1, tag);
        for (int k = 0; k < n; k++) begin
            rbyte(ref_val(ref_ctr), k < n - 1, tag);
            ref_ctr = (ref_ctr + 1) & 32'h7FFF;
        end
        chk(sda_oe == 1'b0, "R8 released after NACK", int'(sda_oe), 0);
        send_stop();
    endtask

    task automatic rd_rand(input int addr, input int n, input string tag);
        send_start();
        send_addr(addr, tag);
        rd_cur(n, tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic s;
        logic [7:0] d [$];
        repeat (10) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        chk(sda_oe == 1'b0, "R1 reset oe", int'(sda_oe), 0);
        chk(mem_we == 1'b0, "R1 reset we", int'(mem_we), 0);

        // R2: strap mismatch, then further bytes ignored
        send_start();
        wbyte({4'b1010, 3'b011, 1'b0}, 1'b0, "R2 strap mismatch");
        wbyte(8'h00, 1'b0, "R2 ignored byte");
        send_stop();
        send_start();
        wbyte({4'b1011, STRAP, 1'b0}, 1'b0, "R2 prefix mismatch");
        send_stop();

        // R1 R4: byte write
        d = {8'h5A};
        wr_seq(32'h0123, d, "R1 R4 byte write");
        // R7 random read, R6 current read
        rd_rand(32'h0123, 1, "R7 random read");
        rd_cur(1, "R6 current read");
        rd_cur(2, "R6 persistent counter");

        // R5: page wrap
        d = {8'hA1, 8'hA2, 8'hA3, 8'hA4};
        wr_seq(32'h007E, d, "R5 page write");
        rd_rand(32'h007E, 2, "R5 page tail");
        rd_rand(32'h0040, 3, "R5 page head");

        // R8 sequential read, R9 wrap over array end
        rd_rand(32'h0200, 5, "R8 sequential read");
        rd_rand(32'h7FFE, 3, "R9 read wrap");
        rd_cur(1, "R9 counter after wrap");

        // R10: high address bit ignored
        d = {8'h77};
        wr_seq(32'h8005, d, "R10 high bit write");
        rd_rand(32'h0005, 1, "R10 read back");

        // R11: start in mid data byte
        send_start();
        send_addr(32'h1234, "R11 address");
        for (int i = 0; i < 4; i++) bitx(1'b0, s);
        rd_cur(1, "R11 read after abort");
        chk(ref_val(32'h1234) == dflt(32'h1234), "R11 model untouched", int'(ref_val(32'h1234)), int'(dflt(32'h1234)));

        repeat (20) @(negedge clk);
        chk(exp_wr_q.size() == 0, "R4 all writes seen", exp_wr_q.size(), 0);
        chk(oe_viol == 0, "R3 oe stable while scl high", oe_viol, 0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule